// File: doc/BRIEF.md
# Frequency-Scaled System Counter

This block is a free-running 64-bit system counter whose update rate can be lowered without losing track of time. A small bank of 32-bit words holds the frequency modes, with values in Hz. Word 0 is the base frequency. The following words are slower alternatives, and a zero word ends the list. When a slower mode is active, the counter updates only once every N clock cycles, where N is the base-to-selected frequency ratio, and each update adds N. The count therefore keeps advancing at base-frequency resolution when averaged over each interval.

The alternatives are limited to power-of-two divisors of the base. The increment is then a shift amount, and the update gate is a masked prescaler compare. A mode request is validated against the first zero word and against the divisor rule. An accepted request waits in a pending slot and is applied on the next update. This way no interval is split or counted twice. The table words are writable in the default build, so start-up code can load them. A parameter turns the bank into constants.

Top module: `freq_scaled_counter`

## Requirements
- R1: Entry n of the table is read at byte address 0x020 + 4*n. After reset, entry i holds BASE_FREQ >> i for i < INIT_MODES and zero otherwise. With the defaults (BASE_FREQ=100000000, INIT_MODES=4, ENTRIES=8), entries 0..3 are 100000000, 50000000, 25000000 and 12500000, and entry 4 is 0.
- R2: A read of an address past the last implemented entry returns zero. A write there changes nothing that can be read back.
- R3: When WRITABLE=1, a write to an implemented entry address stores the 32-bit data, and the next read of that address returns it.
- R4: After reset, count is 0 and activeMode is 0. In mode 0, count increases by 1 on every clock edge where countEn is high.
- R5: While countEn is low, count does not change.
- R6: An accepted request takes effect on the next counter update. activeMode changes on the same clock edge as that update and never between updates.
- R7: A request whose index is at or past the first zero entry is rejected, and the current mode is kept.
- R8: A request for an entry that is not the base frequency divided by a power of two is rejected, and the current mode is kept.
- R9: In a mode with ratio r = 2^k, count increases by r once every r enabled cycles. It stays unchanged in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Table write strobe |
| cfgAddr | input | 12 | Byte address for table read and write |
| cfgWrData | input | 32 | Table write data |
| cfgRdData | output | 32 | Table read data (combinational from cfgAddr) |
| countEn | input | 1 | Counting enable |
| modeReq | input | 1 | Mode change request strobe |
| modeIdx | input | 3 | Requested table entry index |
| count | output | 64 | Counter value |
| activeMode | output | 3 | Index of the active table entry |

## Verification
The checker assumes that countEn and the mode request are synchronous to the clock and that reset is asserted before the first meaningful edge. Under those conditions, every change of the count is a single power of two, and a mode change always coincides with a count update. The stimulus drives every input half a cycle away from the sampling edge. It rewrites table entries only while a request is not pending, so each request is judged against the table as it stood when the request was made.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int SHIFT_W = 5;
  localparam int COUNT_W = 64;
  localparam int WORD_W  = 32;

  typedef struct packed {
    logic               tick;
    logic [SHIFT_W-1:0] incShift;
  } fsc_strobe_t;
endpackage

// File: rtl/fsc_table.sv
module fsc_table #(
  parameter int          ENTRIES    = 8,
  parameter int          INIT_MODES = 4,
  parameter logic [31:0] BASE_FREQ  = 32'd100_000_000,
  parameter bit          WRITABLE   = 1'b1,
  parameter int          ADDR_W     = 12,
  parameter int          TABLE_BASE = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [31:0]       cfgWrData,
  output logic [31:0]       cfgRdData,
  output logic [31:0]       tableVals [ENTRIES]
);
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [31:0] initVal(int i);
    return (i < INIT_MODES) ? (BASE_FREQ >> i) : 32'd0;
  endfunction

  logic [ADDR_W-1:0] offset;
  logic              hit;
  logic [IDX_W-1:0]  entryIdx;
  logic              wrEff;

  assign offset   = cfgAddr - ADDR_W'(TABLE_BASE);
  assign hit      = (cfgAddr >= ADDR_W'(TABLE_BASE)) && (offset[1:0] == 2'b00) &&
                    ((offset >> 2) < ADDR_W'(ENTRIES));
  assign entryIdx = offset[IDX_W+1:2];
  assign wrEff    = cfgWrEn && WRITABLE && hit;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                     tableVals[i] <= initVal(i);
      else if (wrEff && (entryIdx == IDX_W'(i)))     tableVals[i] <= cfgWrData;
    end
  end

  assign cfgRdData = hit ? tableVals[entryIdx] : 32'd0;
endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             countEn,
  input  logic             modeReq,
  input  logic [IDX_W-1:0] modeIdx,
  input  logic [31:0]      tableVals [ENTRIES],
  output logic [IDX_W-1:0] activeMode,
  output fsc_strobe_t      strobe
);
  logic [SHIFT_W-1:0] activeShift, pendShift, reqShift;
  logic [IDX_W-1:0]   pendIdx;
  logic               pendValid;
  logic [31:0]        presc, prescMask, selFreq;
  logic [IDX_W:0]     firstZero;
  logic               divisorOk, accept, tick;

  // Locate the terminator and the shift that maps the requested entry onto the base.
  always_comb begin
    firstZero = (IDX_W+1)'(ENTRIES);
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (tableVals[i] == 32'd0) firstZero = (IDX_W+1)'(i);
    selFreq = tableVals[modeIdx];
    divisorOk = 1'b0;
    reqShift  = '0;
    for (int k = 31; k >= 0; k--)
      if (({32'd0, selFreq} << k) == {32'd0, tableVals[0]}) begin
        divisorOk = 1'b1;
        reqShift  = SHIFT_W'(k);
      end
  end

  assign accept    = modeReq && ({1'b0, modeIdx} < firstZero) && divisorOk;
  assign prescMask = 32'((64'd1 << activeShift) - 64'd1);
  assign tick      = countEn && (presc == prescMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc       <= '0;
      activeShift <= '0;
      activeMode  <= '0;
      pendValid   <= 1'b0;
      pendShift   <= '0;
      pendIdx     <= '0;
    end else begin
      if (tick) begin
        presc <= '0;
        if (pendValid) begin
          activeShift <= pendShift;
          activeMode  <= pendIdx;
          pendValid   <= 1'b0;
        end
      end else if (countEn) begin
        presc <= presc + 32'd1;
      end
      if (accept) begin
        pendValid <= 1'b1;
        pendShift <= reqShift;
        pendIdx   <= modeIdx;
      end
    end
  end

  assign strobe.tick     = tick;
  assign strobe.incShift = activeShift;
endmodule

// File: rtl/fsc_datapath.sv
module fsc_datapath
  import fsc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  fsc_strobe_t        strobe,
  output logic [COUNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            count <= '0;
    else if (strobe.tick) count <= count + (COUNT_W'(1) << strobe.incShift);
  end
endmodule

// File: rtl/freq_scaled_counter.sv
module freq_scaled_counter
  import fsc_pkg::*;
#(
  parameter int          ENTRIES    = 8,
  parameter int          INIT_MODES = 4,
  parameter logic [31:0] BASE_FREQ  = 32'd100_000_000,
  parameter bit          WRITABLE   = 1'b1,
  parameter int          ADDR_W     = 12,
  localparam int         IDX_W      = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [ADDR_W-1:0]  cfgAddr,
  input  logic [31:0]        cfgWrData,
  output logic [31:0]        cfgRdData,
  input  logic               countEn,
  input  logic               modeReq,
  input  logic [IDX_W-1:0]   modeIdx,
  output logic [COUNT_W-1:0] count,
  output logic [IDX_W-1:0]   activeMode
);
  logic [31:0] tableVals [ENTRIES];
  fsc_strobe_t strobe;

  fsc_table #(
    .ENTRIES(ENTRIES), .INIT_MODES(INIT_MODES), .BASE_FREQ(BASE_FREQ),
    .WRITABLE(WRITABLE), .ADDR_W(ADDR_W), .TABLE_BASE(32)
  ) table_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .tableVals(tableVals)
  );

  fsc_ctrl #(.ENTRIES(ENTRIES)) ctrl_i (
    .clk(clk), .rstN(rstN), .countEn(countEn), .modeReq(modeReq),
    .modeIdx(modeIdx), .tableVals(tableVals), .activeMode(activeMode),
    .strobe(strobe)
  );

  fsc_datapath datapath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(count)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             countEn,
  input logic [63:0]      count,
  input logic [IDX_W-1:0] activeMode
);
  AST_RESET_STATE: assert property (@(posedge clk)
    !rstN |=> (count == 64'd0 && activeMode == '0)); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !countEn |=> $stable(count)); // R5

  AST_MODE_AT_UPDATE: assert property (@(posedge clk) disable iff (!rstN)
    (activeMode != $past(activeMode)) |-> (count != $past(count))); // R6

  AST_POW2_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (count != $past(count)) |-> ($countones(count - $past(count)) == 1)); // R9
endmodule

bind freq_scaled_counter fsc_checker #(.IDX_W(IDX_W)) checker_i (
  .clk(clk), .rstN(rstN), .countEn(countEn), .count(count), .activeMode(activeMode)
);

// File: tb/freq_scaled_counter_tb_top.sv
module freq_scaled_counter_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [11:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic        countEn = 1'b0;
  logic        modeReq = 1'b0;
  logic [2:0]  modeIdx = '0;
  logic [63:0] count;
  logic [2:0]  activeMode;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    bit          isRead;
    bit          chkCnt;
    logic [63:0] expCnt;
    logic [2:0]  expMode;
    logic [31:0] expRd;
  } item_t;
  item_t expQ[$];

  always #2.5 clk = ~clk;

  freq_scaled_counter dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .countEn(countEn),
    .modeReq(modeReq), .modeIdx(modeIdx), .count(count), .activeMode(activeMode)
  );

  // Monitor: compares queued expectations shortly after each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        checks++;
        if (it.isRead) begin
          if (cfgRdData !== it.expRd) begin
            failures++;
            $display("FAIL %s: rdData=%0d expected %0d", it.tag, cfgRdData, it.expRd);
          end
        end else if ((it.chkCnt && count !== it.expCnt) || activeMode !== it.expMode) begin
          failures++;
          $display("FAIL %s: count=%0d mode=%0d expected count=%0d mode=%0d",
                   it.tag, count, activeMode, it.chkCnt ? it.expCnt : count, it.expMode);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        failures++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectCM(string tag, logic [63:0] c, logic [2:0] m);
    item_t it;
    it.tag = tag; it.isRead = 1'b0; it.chkCnt = 1'b1;
    it.expCnt = c; it.expMode = m; it.expRd = '0;
    expQ.push_back(it);
  endtask

  task automatic expectM(string tag, logic [2:0] m);
    item_t it;
    it.tag = tag; it.isRead = 1'b0; it.chkCnt = 1'b0;
    it.expCnt = '0; it.expMode = m; it.expRd = '0;
    expQ.push_back(it);
  endtask

  task automatic expectRd(string tag, logic [11:0] a, logic [31:0] v);
    item_t it;
    cfgAddr = a;
    it.tag = tag; it.isRead = 1'b1; it.chkCnt = 1'b0;
    it.expCnt = '0; it.expMode = '0; it.expRd = v;
    expQ.push_back(it);
    step(1);
  endtask

  task automatic writeWord(logic [11:0] a, logic [31:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    step(1);
    cfgWrEn = 1'b0;
  endtask

  task automatic request(logic [2:0] idx);
    modeReq = 1'b1; modeIdx = idx;
    step(1);
    modeReq = 1'b0;
  endtask

  initial begin
    logic [63:0] snap;
    step(3);
    rstN = 1'b1;
    expectCM("R4 reset state", 64'd0, 3'd0);
    step(1);

    expectRd("R1 entry0 base", 12'h020, 32'd100_000_000);
    expectRd("R1 entry3", 12'h02C, 32'd12_500_000);
    expectRd("R1 entry4 terminator", 12'h030, 32'd0);
    expectRd("R2 beyond table read", 12'h040, 32'd0);
    writeWord(12'h044, 32'hDEAD_BEEF);
    expectRd("R2 beyond table write ignored", 12'h044, 32'd0);

    step(3);
    expectCM("R5 disabled holds", 64'd0, 3'd0);

    countEn = 1'b1;
    step(10);
    expectCM("R4 base mode increments by one", 64'd10, 3'd0);

    request(3'd2);
    expectCM("R6 pending until update", 64'd11, 3'd0);
    step(1);
    expectCM("R6 mode 2 applied at update", 64'd12, 3'd2);
    step(3);
    expectCM("R9 no update inside interval", 64'd12, 3'd2);
    step(1);
    expectCM("R9 ratio 4 step", 64'd16, 3'd2);
    step(4);
    expectCM("R9 second ratio 4 step", 64'd20, 3'd2);

    request(3'd1);
    expectCM("R6 request mid-interval waits", 64'd20, 3'd2);
    step(2);
    expectCM("R6 still waiting for boundary", 64'd20, 3'd2);
    step(1);
    expectCM("R6 mode 1 applied at boundary", 64'd24, 3'd1);
    step(1);
    expectCM("R9 ratio 2 no update", 64'd24, 3'd1);
    step(1);
    expectCM("R9 ratio 2 step", 64'd26, 3'd1);

    request(3'd4);
    step(3);
    expectM("R7 index at terminator rejected", 3'd1);
    request(3'd6);
    step(3);
    expectM("R7 index past terminator rejected", 3'd1);

    countEn = 1'b0;
    writeWord(12'h02C, 32'd12345);
    expectRd("R3 written entry reads back", 12'h02C, 32'd12345);
    countEn = 1'b1;
    request(3'd3);
    step(3);
    expectM("R8 non power-of-two divisor rejected", 3'd1);

    countEn = 1'b0;
    writeWord(12'h02C, 32'd12_500_000);
    writeWord(12'h028, 32'd0);
    countEn = 1'b1;
    request(3'd3);
    step(3);
    expectM("R7 moved terminator rejects index 3", 3'd1);

    request(3'd0);
    step(3);
    expectM("R6 return to base mode", 3'd0);

    countEn = 1'b0;
    step(1);
    snap = count;
    step(5);
    expectCM("R5 disabled holds after run", snap, 3'd0);
    step(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule